// File: doc/BRIEF.md
# Latched Serial-to-Parallel Sink Driver Core

This block turns a slow serial bit stream into a wide vector of "sink on" requests for an array of high-voltage current-sink channels. Bits arrive on a serial data line. A 32-stage shift register moves them one position on every high-to-low transition of an externally supplied serial clock. The last stage is presented on a cascade output, so several drivers can be chained. A bank of holding registers is transparent while the load-enable input is high and keeps its contents while that input is low. A gating matrix of blanking and polarity then produces the per-channel request.

Both the serial clock and the control inputs are asynchronous to the fast system clock. They pass through synchronizers, and a small edge-tracking state machine turns the serial clock into single-cycle shift strobes. The machine has three states. `SC_LOW` means the serial clock was last seen low. `SC_HIGH` means it was seen high, and in this state the data bit is held. `SC_FALL` is a one-cycle state that issues the shift strobe. The transitions are named as follows. `rise`: SC_LOW to SC_HIGH when the synchronized clock is high. `fall`: SC_HIGH to SC_FALL when it is low. `refire`: SC_FALL to SC_HIGH when it is high again. `settle`: SC_FALL to SC_LOW otherwise. Every state holds for as long as its exit condition is absent. Reset enters SC_LOW.

Top module: `sink_array_driver`

## Requirements
- R1: Each high-to-low transition of `ser_clk_i` shifts the register by one place. The value of `ser_dat_i` goes into stage 1 (bit 0), and stage k moves to stage k+1.
- R2: A low-to-high transition of `ser_clk_i`, or a steady `ser_clk_i`, leaves the shift register unchanged.
- R3: `chain_o` always equals stage 32 (bit 31) of the shift register.
- R4: `load_en_i`, `gate_i` and `sense_i` have no effect on shifting.
- R5: While `load_en_i` is high, the holding registers follow the shift register, including across shifts.
- R6: While `load_en_i` is low, the holding registers keep their value, whatever is shifted.
- R7: With `gate_i` low and `sense_i` low, every bit of `sink_on_o` is 1.
- R8: With `gate_i` low and `sense_i` high, every bit of `sink_on_o` is 0.
- R9: With `gate_i` high and `sense_i` high, `sink_on_o[k]` equals holding bit k.
- R10: With `gate_i` high and `sense_i` low, `sink_on_o[k]` is the inverse of holding bit k.
- R11: After 32 falling edges, the first bit sent sits on channel 32 (`sink_on_o[31]`) and the most recent bit on channel 1 (`sink_on_o[0]`). Sending word w from its MSB down therefore loads w.
- R12: A low `rst_n` clears the shift register and the holding registers at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock; the register shifts on its falling edge |
| ser_dat_i | input | 1 | Serial data bit |
| load_en_i | input | 1 | High: holding registers track the shift register; low: they hold |
| gate_i | input | 1 | Low forces every channel to a uniform state |
| sense_i | input | 1 | Polarity select for the channel mapping |
| chain_o | output | 1 | Cascade output carrying stage 32 |
| sink_on_o | output | 32 | Per-channel sink-on requests, bit 0 = channel 1 |

## Verification
The shift strobe and the holding-register capture can land in the same system cycle. This happens when a falling serial edge arrives while load enable is open. The bench provokes it by raising load enable first and then completing a serial bit. It expects the output to show the newly shifted vector a few cycles later. The opposite case is also covered. A full word is shifted with load enable closed and the controls toggling, and the outputs must not move. After a load pulse the outputs must show exactly the new word.

// File: rtl/sink_drv_pkg.sv
package sink_drv_pkg;

    // Edge-tracking states for the serial clock
    typedef enum logic [1:0] {
        SC_LOW  = 2'd0,
        SC_HIGH = 2'd1,
        SC_FALL = 2'd2
    } sclk_state_t;

endpackage

// File: rtl/ser_edge_tracker.sv
module ser_edge_tracker
    import sink_drv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_dat_i,
    output logic step_o,
    output logic bit_o
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] ck_pipe;
    logic [TOP:0] dt_pipe;
    logic         ck_s;
    logic         dt_s;
    logic         held_q;

    sclk_state_t state_q;
    sclk_state_t state_d;

    // Synchronizers for the serial clock and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_pipe <= '0;
            dt_pipe <= '0;
        end else begin
            ck_pipe <= {ck_pipe[TOP-1:0], ser_clk_i};
            dt_pipe <= {dt_pipe[TOP-1:0], ser_dat_i};
        end
    end

    assign ck_s = ck_pipe[TOP];
    assign dt_s = dt_pipe[TOP];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_LOW;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_LOW:  if (ck_s)  state_d = SC_HIGH;             // rise
            SC_HIGH: if (!ck_s) state_d = SC_FALL;             // fall
            SC_FALL: state_d = ck_s ? SC_HIGH : SC_LOW;        // refire / settle
            default: state_d = SC_LOW;
        endcase
    end

    // Data is captured while the serial clock is seen high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 held_q <= 1'b0;
        else if (state_q == SC_HIGH) held_q <= dt_s;
    end

    // Outputs
    always_comb begin
        step_o = 1'b0;
        unique case (state_q)
            SC_FALL: step_o = 1'b1;
            default: step_o = 1'b0;
        endcase
        bit_o = held_q;
    end

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R1
    fall_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_FALL) |-> ($past(state_q) == SC_HIGH));

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] stages_o
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr_q <= '0;
        else if (step_i) sr_q <= {sr_q[WIDTH-2:0], bit_i};
    end

    assign stages_o = sr_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(sr_q));

    // R1
    entry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (sr_q[0] == $past(bit_i)) && (sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0])));

endmodule

// File: rtl/hold_bank.sv
module hold_bank #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0]     en_pipe;
    logic             open_s;
    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_pipe <= '0;
        else        en_pipe <= {en_pipe[TOP-1:0], open_i};
    end

    assign open_s = en_pipe[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_r <= '0;
        else if (open_s) q_r <= d_i;
    end

    assign q_o = q_r;

    // R6
    closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_s |=> $stable(q_r));

    // R5
    open_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_s |=> (q_r == $past(d_i)));

endmodule

// File: rtl/gate_matrix.sv
module gate_matrix #(
    parameter int WIDTH = 32
) (
    input  logic             gate_i,
    input  logic             sense_i,
    input  logic [WIDTH-1:0] q_i,
    output logic [WIDTH-1:0] on_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_ch
        always_comb begin
            if (gate_i) on_o[g] = sense_i ? q_i[g] : ~q_i[g];
            else        on_o[g] = ~sense_i;
        end
    end

endmodule

// File: rtl/sink_array_driver.sv
module sink_array_driver #(
    parameter int CHANNELS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk_i,
    input  logic                ser_dat_i,
    input  logic                load_en_i,
    input  logic                gate_i,
    input  logic                sense_i,
    output logic                chain_o,
    output logic [CHANNELS-1:0] sink_on_o
);

    localparam int LAST = CHANNELS - 1;

    logic                step;
    logic                nbit;
    logic [CHANNELS-1:0] stages;
    logic [CHANNELS-1:0] held;

    ser_edge_tracker #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk_i),
        .ser_dat_i (ser_dat_i),
        .step_o    (step),
        .bit_o     (nbit)
    );

    shift_chain #(.WIDTH(CHANNELS)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .bit_i    (nbit),
        .stages_o (stages)
    );

    hold_bank #(.WIDTH(CHANNELS), .SYNC_STAGES(SYNC_STAGES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (load_en_i),
        .d_i    (stages),
        .q_o    (held)
    );

    gate_matrix #(.WIDTH(CHANNELS)) u_gate (
        .gate_i  (gate_i),
        .sense_i (sense_i),
        .q_i     (held),
        .on_o    (sink_on_o)
    );

    assign chain_o = stages[LAST];

    // R7 R8
    blank_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |-> (($countones(sink_on_o) == 0) || ($countones(sink_on_o) == CHANNELS)));

    // R3
    chain_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(chain_o));

endmodule

// File: tb/sim_sink_array_driver.sv
module sim_sink_array_driver;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N    = 32;
    localparam int HALF = 8;

    logic clk = 0, rst_n = 0, sck = 0, sdi = 0, le = 0, gate = 1, sense = 1;
    logic         chain;
    logic [N-1:0] sink;

    int total = 0, bad = 0;
    bit done = 0;
    logic [N-1:0] m_sr = '0, m_lat = '0;

    always #2 clk = ~clk;

    sink_array_driver u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_dat_i(sdi),
        .load_en_i(le), .gate_i(gate), .sense_i(sense),
        .chain_o(chain), .sink_on_o(sink)
    );

    function automatic logic [N-1:0] want();
        if (gate) return sense ? m_lat : ~m_lat;
        return sense ? '0 : '1;
    endfunction

    task automatic chk_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        sdi = b; idle(2);
        sck = 1; idle(HALF);
        sck = 0; idle(HALF);
        m_sr = {m_sr[N-2:0], b};
        if (le) m_lat = m_sr;
    endtask

    task automatic send_word(logic [N-1:0] w);
        for (int i = N - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_latch();
        le = 1; idle(8);
        m_lat = m_sr;
        le = 0; idle(8);
    endtask

    task automatic t_reset();
        rst_n = 0; idle(5);
        chk_vec("R12 reset outputs", sink, '0);
        chk_bit("R12 reset chain", chain, 1'b0);
        rst_n = 1; idle(4);
    endtask

    task automatic t_load();
        send_word(32'hA5A5_0F0F);
        pulse_latch();
        chk_vec("R9 R11 R1 loaded word", sink, 32'hA5A5_0F0F);
    endtask

    task automatic t_matrix();
        sense = 0; idle(2);
        chk_vec("R10 inverted", sink, ~32'hA5A5_0F0F);
        gate = 0; idle(2);
        chk_vec("R7 all on", sink, '1);
        sense = 1; idle(2);
        chk_vec("R8 all off", sink, '0);
        gate = 1; idle(2);
        chk_vec("R9 restored", sink, want());
    endtask

    task automatic t_hold_controls();
        logic [N-1:0] old;
        old = m_lat;
        gate = 0;
        for (int i = N - 1; i >= 16; i--) send_bit(32'h1234_ABCD >> i);
        gate = 1; sense = 0;
        for (int i = 15; i >= 0; i--) send_bit(32'h1234_ABCD >> i);
        sense = 1; idle(2);
        chk_vec("R6 held while closed", sink, old);
        pulse_latch();
        chk_vec("R4 shift unaffected by controls", sink, 32'h1234_ABCD);
    endtask

    task automatic t_chain();
        send_word(32'h8000_0001);
        chk_bit("R3 chain after full word", chain, 1'b1);
        send_bit(1'b0);
        chk_bit("R3 chain after one more", chain, 1'b0);
    endtask

    task automatic t_rise_only();
        sck = 1; idle(HALF * 2);
        pulse_latch();
        chk_vec("R2 rise does not shift", sink, m_sr);
        send_bit(1'b1);
        pulse_latch();
        chk_vec("R1 fall after rise", sink, m_sr);
    endtask

    task automatic t_transparent();
        le = 1; idle(6);
        m_lat = m_sr;
        send_bit(1'b1);
        idle(4);
        chk_vec("R5 transparent shift 1", sink, m_sr);
        send_bit(1'b0);
        idle(4);
        chk_vec("R5 transparent shift 2", sink, m_sr);
        le = 0; idle(8);
    endtask

    task automatic t_order();
        send_bit(1'b1);
        for (int i = 0; i < N - 1; i++) send_bit(1'b0);
        pulse_latch();
        chk_vec("R11 first bit at channel 32", sink, 32'h8000_0000);
        send_bit(1'b1);
        pulse_latch();
        chk_vec("R11 newest bit at channel 1", sink, 32'h0000_0001);
    endtask

    task automatic t_async_reset();
        send_word(32'hFFFF_FFFF);
        pulse_latch();
        @(negedge clk);
        #1 rst_n = 0;
        #0.5;
        chk_vec("R12 async clear outputs", sink, '0);
        chk_bit("R12 async clear chain", chain, 1'b0);
        m_sr = '0; m_lat = '0;
        idle(3); rst_n = 1; idle(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_matrix();
        t_hold_controls();
        t_chain();
        t_rise_only();
        t_transparent();
        t_order();
        t_async_reset();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule